// File: doc/BRIEF.md
# I2C Slave Command Decoder for a Four-Channel DAC Register Bank

This block is the serial front end of a four-channel, 16-bit DAC. It samples the I2C clock and data lines with the system clock and finds START, repeated START and STOP conditions. It answers one 7-bit device address, and also a shared broadcast address for writes. It turns the byte stream into write strobes for a channel register bank. A strobe carries the channel, the 16-bit code, a power-down field and a load-mode field. On a read it sends back the contents of the selected channel. It drives only SDA, as an open-drain pull-down. It never touches SCL.

A write transfer is the address byte, then a control byte, then MSB/LSB pairs. Each pair produces one strobe. In ordinary-data mode the pairs may repeat without limit until STOP or repeated START. A read writes the control byte first. The master then issues a repeated START, sends the address again with the read bit set, and the slave returns two or three bytes. A master-code byte for high-speed mode is recognised but not acknowledged. The mode flag rises at the next repeated START and drops at STOP.

The decoder is one state machine. **IDLE** waits for START. **ADDR** receives the first byte of a transfer. **CTRL** takes the control byte. **MSB** and **LSB** take data pairs. **TX** shifts readback bytes out. **IGNORE** sits out the rest of a transfer that is not for this device or has ended.

The transitions are:
- STOP from any state goes to IDLE.
- START from any state goes to ADDR.
- ADDR goes to CTRL on a matching write address, to TX on a matching read address, and to IGNORE on a master code or a foreign address.
- CTRL goes to MSB.
- MSB goes to LSB.
- LSB goes back to MSB in data mode, or to IGNORE in power-down mode.
- TX goes to IGNORE when the master does not acknowledge a byte.

Top module: `i2c_dac_cmd_slave`

## Requirements
- R1: The device acknowledges an address byte whose upper seven bits equal 1,0,0,1,1,A1,A0 (MSB first). A1/A0 are the values on `a_pins[1]`/`a_pins[0]` captured in the first clock after reset is released. Later changes on `a_pins` have no effect.
- R2: An acknowledge holds SDA low for the whole high phase of the ninth SCL pulse. SDA is released once SCL falls again, and `sda_oe` never changes while SCL stays high.
- R3: Address 1001000 is acknowledged with the write bit (0) regardless of the latched pins. With the read bit (1) it is not acknowledged.
- R4: The control byte uses bits 5:4 as load mode, bits 2:1 as channel and bit 0 as the power-down flag; the other bits are ignored. After the LSB byte, one `wr_stb` pulse is issued at its acknowledge. The pulse carries `wr_chan`=control[2:1], `wr_load`=control[5:4] and `wr_data`={MSB,LSB}.
- R5: With the power-down flag clear, MSB/LSB pairs repeat after one control byte. Every pair is acknowledged and gives exactly one strobe, with `wr_pd_en`=0.
- R6: With the power-down flag set, the strobe after the first pair carries `wr_pd_en`=1 and `wr_pd`=MSB[7:6]. Later data bytes in that transfer are not acknowledged and give no strobe.
- R7: `rd_chan` follows control[2:1]. After a read address, the slave sends `rd_word[15:8]` and then `rd_word[7:0]` when the flag is clear. When the flag is set it sends {`rd_word[17:16]`,000000} first, then the same two bytes. It releases SDA after the master does not acknowledge.
- R8: A first byte matching 00001xxx is not acknowledged. `hs_mode` rises at the following repeated START and falls at STOP.
- R9: A START or STOP inside a byte abandons that byte: no strobe results, and the next address byte is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| a_pins | input | 2 | Address select pins, captured after reset |
| wr_stb | output | 1 | One-clock write strobe to the register bank |
| wr_chan | output | 2 | Channel of the write |
| wr_data | output | 16 | Code of the write |
| wr_pd_en | output | 1 | Write updates the power-down field |
| wr_pd | output | 2 | Power-down mode from MSB[7:6] |
| wr_load | output | 2 | Load-mode field of the control byte |
| rd_chan | output | 2 | Channel selected for readback |
| rd_word | input | 18 | Selected channel: power-down bits 17:16, code 15:0 |
| hs_mode | output | 1 | High-speed mode active |

## Verification
The bench sweeps all four pin settings against all four address candidates. It changes the pins after reset each time, so a decoder that follows the live pins gives wrong acknowledges. It streams several data pairs after one control byte, which catches a decoder that expects a control byte before every pair or drops a strobe. It sends a byte past the power-down pair, which catches an acknowledge where a refusal is due. It runs two- and three-byte readbacks against known register values, which exposes an off-by-one in byte order. It checks that a broadcast read and a master code are refused. It aborts transfers in mid-byte, which catches a bit counter that is not cleared.

// File: rtl/i2cd_pkg.sv
`timescale 1ns/1ps
package i2cd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CTRL,
        ST_MSB,
        ST_LSB,
        ST_TX,
        ST_IGNORE
    } bus_state_t;

    localparam logic [4:0] DEV_PREFIX = 5'b10011;
    localparam logic [6:0] BCAST_ADDR = 7'b1001000;
    localparam logic [4:0] HS_PREFIX  = 5'b00001;

endpackage

// File: rtl/i2cd_line_sync.sv
`timescale 1ns/1ps
module i2cd_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe[s] <= '1;
                end else if (s == 0) begin
                    pipe[s] <= din;
                end else begin
                    pipe[s] <= pipe[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/i2cd_bus_events.sv
`timescale 1ns/1ps
module i2cd_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign scl_rise = scl & ~scl_q;
    assign scl_fall = ~scl & scl_q;
    assign start_c  = scl & scl_q & sda_q & ~sda;
    assign stop_c   = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2c_dac_cmd_slave.sv
`timescale 1ns/1ps
module i2c_dac_cmd_slave
    import i2cd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [1:0]  a_pins,
    output logic        wr_stb,
    output logic [1:0]  wr_chan,
    output logic [15:0] wr_data,
    output logic        wr_pd_en,
    output logic [1:0]  wr_pd,
    output logic [1:0]  wr_load,
    output logic [1:0]  rd_chan,
    input  logic [17:0] rd_word,
    output logic        hs_mode
);
    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);

    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_c, stop_c;

    i2cd_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(line_s)
    );
    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2cd_bus_events u_ev (
        .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_c(start_c), .stop_c(stop_c)
    );

    bus_state_t       state, state_nx;
    logic [CNT_W-1:0] bit_cnt;
    logic             in_ack, ack_now;
    logic [7:0]       shreg, msb_q, tx_sh, cur_byte;
    logic [1:0]       load_q, chan_q, tx_idx, addr_lat;
    logic             pd_q, armed, hs_pend;
    logic [2:0]       eff_idx;

    wire byte_done = scl_fall && (bit_cnt == CNT_W'(BYTE_BITS)) && !in_ack;
    wire ack_end   = scl_fall && in_ack;
    wire ack_hi    = scl_rise && in_ack;
    wire is_hs     = (shreg[7:3] == HS_PREFIX);

    // Next-state decision and acknowledge choice
    always_comb begin
        state_nx = state;
        ack_now  = 1'b0;
        if (stop_c) begin
            state_nx = ST_IDLE;
        end else if (start_c) begin
            state_nx = ST_ADDR;
        end else if (byte_done) begin
            unique case (state)
                ST_ADDR: begin
                    if (is_hs) begin
                        state_nx = ST_IGNORE;
                    end else if (shreg[7:1] == {DEV_PREFIX, addr_lat}) begin
                        ack_now  = 1'b1;
                        state_nx = shreg[0] ? ST_TX : ST_CTRL;
                    end else if (shreg[7:1] == BCAST_ADDR && !shreg[0]) begin
                        ack_now  = 1'b1;
                        state_nx = ST_CTRL;
                    end else begin
                        state_nx = ST_IGNORE;
                    end
                end
                ST_CTRL: begin ack_now = 1'b1; state_nx = ST_MSB; end
                ST_MSB:  begin ack_now = 1'b1; state_nx = ST_LSB; end
                ST_LSB:  begin
                    ack_now  = 1'b1;
                    state_nx = pd_q ? ST_IGNORE : ST_MSB;
                end
                default: ;
            endcase
        end else if (ack_hi && state == ST_TX && sda_s) begin
            state_nx = ST_IGNORE;
        end
    end

    // Readback byte selection
    always_comb begin
        eff_idx = pd_q ? {1'b0, tx_idx} : ({1'b0, tx_idx} + 3'd1);
        unique case (eff_idx)
            3'd0:    cur_byte = {rd_word[17:16], 6'b0};
            3'd1:    cur_byte = rd_word[15:8];
            3'd2:    cur_byte = rd_word[7:0];
            default: cur_byte = 8'hFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;   in_ack  <= 1'b0;  shreg   <= '0;
            msb_q   <= '0;   tx_sh   <= '1;    tx_idx  <= '0;
            load_q  <= '0;   chan_q  <= '0;    pd_q    <= 1'b0;
            armed   <= 1'b0; addr_lat <= '0;   hs_pend <= 1'b0;
            hs_mode <= 1'b0; sda_oe  <= 1'b0;  wr_stb  <= 1'b0;
            wr_chan <= '0;   wr_data <= '0;    wr_pd_en <= 1'b0;
            wr_pd   <= '0;   wr_load <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (!armed) begin
                addr_lat <= a_pins;
                armed    <= 1'b1;
            end
            if (stop_c) begin
                bit_cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
                hs_mode <= 1'b0; hs_pend <= 1'b0;
            end else if (start_c) begin
                bit_cnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
                if (hs_pend) hs_mode <= 1'b1;
                hs_pend <= 1'b0;
            end else begin
                if (scl_rise && !in_ack && bit_cnt != CNT_W'(BYTE_BITS)) begin
                    shreg   <= {shreg[6:0], sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (byte_done) begin
                    in_ack <= 1'b1;
                    sda_oe <= ack_now;
                    unique case (state)
                        ST_ADDR: begin
                            if (is_hs) hs_pend <= 1'b1;
                            tx_idx <= '0;
                        end
                        ST_CTRL: begin
                            load_q <= shreg[5:4];
                            chan_q <= shreg[2:1];
                            pd_q   <= shreg[0];
                        end
                        ST_MSB: msb_q <= shreg;
                        ST_LSB: begin
                            wr_stb   <= 1'b1;
                            wr_chan  <= chan_q;
                            wr_load  <= load_q;
                            wr_data  <= {msb_q, shreg};
                            wr_pd_en <= pd_q;
                            wr_pd    <= msb_q[7:6];
                        end
                        ST_TX: tx_idx <= tx_idx + 1'b1;
                        default: ;
                    endcase
                end
                if (ack_end) begin
                    in_ack  <= 1'b0;
                    bit_cnt <= '0;
                    if (state == ST_TX) begin
                        sda_oe <= ~cur_byte[7];
                        tx_sh  <= {cur_byte[6:0], 1'b1};
                    end else begin
                        sda_oe <= 1'b0;
                    end
                end
                if (scl_fall && !in_ack && state == ST_TX &&
                    bit_cnt != '0 && bit_cnt != CNT_W'(BYTE_BITS)) begin
                    sda_oe <= ~tx_sh[7];
                    tx_sh  <= {tx_sh[6:0], 1'b1};
                end
            end
        end
    end

    assign rd_chan = chan_q;
endmodule

// File: rtl/i2cd_checker.sv
`timescale 1ns/1ps
module i2cd_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic wr_stb,
    input logic hs_mode
);
    // R2: the pull-down only moves while SCL is low
    a_r2_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe));

    // R4: a write strobe lasts a single clock
    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R4: the strobe comes in the acknowledge slot, with SCL low
    a_r4_strobe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !scl_i);

    // R8: the mode flag rises only on a bus condition, with SCL high
    a_r8_hs_rise_on_condition: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> scl_i);

    // R8: the mode flag falls only on STOP, with SCL high
    a_r8_hs_fall_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_mode) |-> scl_i);
endmodule

bind i2c_dac_cmd_slave i2cd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .hs_mode(hs_mode)
);

// File: tb/sim_i2c_dac_cmd_slave.sv
`timescale 1ns/1ps
module sim_i2c_dac_cmd_slave;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1, m_sda = 1'b1;
    logic [1:0]  a_pins = 2'b00;
    logic        sda_oe, wr_stb, wr_pd_en, hs_mode;
    logic [1:0]  wr_chan, wr_pd, wr_load, rd_chan;
    logic [15:0] wr_data;
    logic [17:0] bank [4];
    logic [17:0] rd_word;
    wire         sda_bus = m_sda & ~sda_oe;

    int checks = 0, errors = 0, stb_cnt = 0;
    logic [1:0]  c_chan, c_pd, c_load;
    logic [15:0] c_data;
    logic        c_pden;
    bit          done = 0;

    always #2.5 clk = ~clk;
    assign rd_word = bank[rd_chan];

    i2c_dac_cmd_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .a_pins(a_pins), .wr_stb(wr_stb), .wr_chan(wr_chan), .wr_data(wr_data),
        .wr_pd_en(wr_pd_en), .wr_pd(wr_pd), .wr_load(wr_load), .rd_chan(rd_chan),
        .rd_word(rd_word), .hs_mode(hs_mode)
    );

    always @(negedge clk) begin
        if (wr_stb) begin
            stb_cnt++;
            c_chan = wr_chan; c_pd = wr_pd; c_load = wr_load;
            c_data = wr_data; c_pden = wr_pd_en;
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wclk(4); m_scl = 1'b1; wclk(8);
        m_sda = 1'b0; wclk(8); m_scl = 1'b0; wclk(8);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wclk(4); m_scl = 1'b1; wclk(8);
        m_sda = 1'b1; wclk(8);
    endtask

    task automatic bit_out(input logic b);
        m_sda = b; wclk(4); m_scl = 1'b1; wclk(8); m_scl = 1'b0; wclk(4);
    endtask

    // ack: low at both ends of the high phase; rel: SDA free after the fall
    task automatic send_byte(input logic [7:0] b, output logic ack, output logic rel);
        logic a1, a2;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        m_sda = 1'b1; wclk(4); m_scl = 1'b1; wclk(1);
        a1 = ~sda_bus; wclk(6); a2 = ~sda_bus; wclk(1);
        m_scl = 1'b0; wclk(4);
        rel = sda_bus;
        ack = a1 & a2;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wclk(4); m_scl = 1'b1; wclk(4); b[i] = sda_bus; wclk(4);
            m_scl = 1'b0; wclk(4);
        end
        m_sda = ~mack; wclk(4); m_scl = 1'b1; wclk(8); m_scl = 1'b0; wclk(4);
        m_sda = 1'b1;
    endtask

    task automatic do_reset(input logic [1:0] pins);
        rst_n = 1'b0; a_pins = pins; wclk(4); rst_n = 1'b1; wclk(4);
    endtask

    localparam logic [7:0] OWN_W = 8'h9A;   // pins 01, write
    localparam logic [7:0] OWN_R = 8'h9B;   // pins 01, read

    initial begin
        logic ack, rel;
        logic [7:0] rb;
        int s0;
        bank[0] = 18'h0_0000; bank[1] = 18'h2_BEEF;
        bank[2] = 18'h0_5555; bank[3] = 18'h1_1234;
        wclk(2);
        do_reset(2'b00);
        chk("R2 reset sda_oe", sda_oe, 0);
        chk("R8 reset hs_mode", hs_mode, 0);
        chk("R4 reset wr_stb", wr_stb, 0);

        // R1: pin sweep; pins changed after reset must not matter
        for (int a = 0; a < 4; a++) begin
            do_reset(a[1:0]);
            a_pins = ~a[1:0];
            for (int c = 0; c < 4; c++) begin
                bus_start();
                send_byte({5'b10011, c[1:0], 1'b0}, ack, rel);
                chk($sformatf("R1 pins=%0d cand=%0d", a, c), ack, (a == c));
                bus_stop();
            end
        end

        do_reset(2'b01);
        // R2 full-phase acknowledge and release
        bus_start();
        send_byte(OWN_W, ack, rel);
        chk("R2 ack held", ack, 1);
        chk("R2 released", rel, 1);
        bus_stop();

        // R3 broadcast
        bus_start(); send_byte(8'h90, ack, rel);
        chk("R3 broadcast write", ack, 1); bus_stop();
        bus_start(); send_byte(8'h91, ack, rel);
        chk("R3 broadcast read", ack, 0); bus_stop();

        // R4 single write: load 10, chan 11, flag 0, reserved bits set
        s0 = stb_cnt;
        bus_start(); send_byte(OWN_W, ack, rel);
        send_byte(8'hEE & 8'hE6 | 8'h26, ack, rel);
        send_byte(8'hA5, ack, rel);
        send_byte(8'h3C, ack, rel);
        chk("R4 lsb ack", ack, 1);
        chk("R4 strobe count", stb_cnt - s0, 1);
        chk("R4 chan", c_chan, 3);
        chk("R4 load", c_load, 2);
        chk("R4 data", c_data, 16'hA53C);
        bus_stop();

        // R5 stream of pairs after one control byte (chan 1, load 00)
        s0 = stb_cnt;
        bus_start(); send_byte(OWN_W, ack, rel); send_byte(8'h02, ack, rel);
        for (int p = 0; p < 3; p++) begin
            logic [15:0] v;
            v = 16'h1234 * (p + 1) + 16'h0F;
            send_byte(v[15:8], ack, rel);
            send_byte(v[7:0], ack, rel);
            chk($sformatf("R5 pair %0d ack", p), ack, 1);
            chk($sformatf("R5 pair %0d count", p), stb_cnt - s0, p + 1);
            chk($sformatf("R5 pair %0d data", p), c_data, v);
            chk($sformatf("R5 pair %0d pd_en", p), c_pden, 0);
            chk($sformatf("R5 pair %0d chan", p), c_chan, 1);
        end
        bus_stop();

        // R6 power-down write, chan 2; further byte refused
        s0 = stb_cnt;
        bus_start(); send_byte(OWN_W, ack, rel); send_byte(8'h05, ack, rel);
        send_byte(8'hC0, ack, rel); send_byte(8'h00, ack, rel);
        chk("R6 strobe", stb_cnt - s0, 1);
        chk("R6 pd_en", c_pden, 1);
        chk("R6 pd bits", c_pd, 3);
        chk("R6 chan", c_chan, 2);
        send_byte(8'h55, ack, rel);
        chk("R6 extra byte nack", ack, 0);
        send_byte(8'h66, ack, rel);
        chk("R6 no extra strobe", stb_cnt - s0, 1);
        bus_stop();

        // R7 two-byte readback of chan 3
        bus_start(); send_byte(OWN_W, ack, rel); send_byte(8'h06, ack, rel);
        chk("R7 rd_chan", rd_chan, 3);
        bus_start(); send_byte(OWN_R, ack, rel);
        chk("R7 read addr ack", ack, 1);
        recv_byte(1'b1, rb); chk("R7 high byte", rb, bank[3][15:8]);
        recv_byte(1'b0, rb); chk("R7 low byte", rb, bank[3][7:0]);
        wclk(2);
        chk("R7 released after nack", sda_bus, 1);
        bus_stop();

        // R7 three-byte readback of chan 1
        bus_start(); send_byte(OWN_W, ack, rel); send_byte(8'h03, ack, rel);
        bus_start(); send_byte(OWN_R, ack, rel);
        recv_byte(1'b1, rb); chk("R7 pd byte", rb, {bank[1][17:16], 6'b0});
        recv_byte(1'b1, rb); chk("R7 high byte 3", rb, bank[1][15:8]);
        recv_byte(1'b0, rb); chk("R7 low byte 3", rb, bank[1][7:0]);
        bus_stop();

        // R8 high-speed master code
        bus_start(); send_byte(8'h09, ack, rel);
        chk("R8 master code nack", ack, 0);
        chk("R8 not yet hs", hs_mode, 0);
        bus_start();
        chk("R8 hs after restart", hs_mode, 1);
        send_byte(OWN_W, ack, rel);
        chk("R8 addr in hs", ack, 1);
        bus_stop();
        chk("R8 hs cleared by stop", hs_mode, 0);

        // R9 partial byte aborted by START, then by STOP
        bus_start();
        bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
        bus_start(); send_byte(OWN_W, ack, rel);
        chk("R9 addr after abort", ack, 1);
        bus_stop();
        s0 = stb_cnt;
        bus_start(); send_byte(OWN_W, ack, rel); send_byte(8'h00, ack, rel);
        send_byte(8'h11, ack, rel);
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_stop();
        chk("R9 no strobe from cut byte", stb_cnt - s0, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule